// File: doc/BRIEF.md
# Multi-Way Sequential Stream Prefetcher

This block sits next to a first-level cache and follows several interleaved sequential reference streams at once. It holds a small number of circular FIFO buffers. Each buffer keeps a run of consecutive cache lines and is compared with incoming cache misses only at its oldest entry. When a miss matches the oldest line of a buffer, the buffer hands that line to the cache, advances, and asks the next memory level for one more line at its far end. Prefetched data stays inside the buffers and never enters the cache through the prefetcher.

A miss that matches no buffer head is reported back as a plain miss, so the cache fetches that line on demand. The least recently used buffer is then flushed and restarted one line past the missing address. Requests to the pipelined next level carry a tag made of the buffer number and the slot number, so returning data lands in its own slot without any search. A response that belongs to a buffer that has since been flushed is dropped. Its slot is not asked for again until that stale response has come back.

The cache holds `miss_valid` and `miss_line` until it sees `done_valid`, then lowers `miss_valid` on the next cycle. Line addresses count whole cache lines.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, `done_valid` and `mem_req_valid` stay low until a miss is presented.
- R2: A miss whose line equals no buffer head gives `done_valid`=1 with `done_hit`=0 on the clock edge after it is first sampled. `done_valid` is a one-cycle pulse, and no lookup takes place in the cycle it is high.
- R3: A buffer allocated at miss line A requests lines A+1 through A+DEPTH, in that order. Each request's tag is buffer*DEPTH + slot, with slots 0 through DEPTH-1 in address order.
- R4: While candidates remain and `mem_req_ready` is high, a new request is accepted on every cycle. While `mem_req_ready` is low, a pending request holds its line and tag unchanged.
- R5: A miss that equals a buffer's head line, with that line's data already returned, gives `done_hit`=1 and `done_data` equal to that data. The buffer then advances and issues exactly one new request, for the old head line + DEPTH, under the tag of the slot it freed.
- R6: A head match whose data has not yet returned produces no `done_valid` until the response arrives. After that it completes as in R5.
- R7: Only head lines are compared. A miss equal to a line held deeper in a buffer is treated as a no-match miss.
- R8: Buffers that have never been used are allocated in index order 0, 1, 2, and so on. After that, the buffer picked for allocation is the one least recently allocated or hit.
- R9: Responses to requests issued before a buffer was flushed are discarded. A flushed slot is not requested again until its stale response has returned.
- R10: The number of requests accepted and not yet answered never exceeds NBUF*DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss presented; held until done |
| miss_line | input | AW | Line address of the miss |
| done_valid | output | 1 | Miss lookup finished (one-cycle pulse) |
| done_hit | output | 1 | Line supplied from a stream buffer |
| done_data | output | DW | Line data when done_hit is set |
| mem_req_valid | output | 1 | Prefetch request to next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_line | output | AW | Line address requested |
| mem_req_tag | output | TW | Buffer and slot of the request |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_tag | input | TW | Tag of the returning line |
| mem_rsp_data | input | DW | Returning line data |

## Verification
The bench runs several patterns. A cold miss checks allocation and the address and tag order of the burst. A walk along one stream tells head hits apart from the refill requests at the tail. A miss on a line whose data is still outstanding shows the difference between a stall and a hit. A miss on a non-head line checks that deeper entries are never matched. Further misses on fresh regions fill every buffer and then force a replacement, which checks the LRU order against a buffer that was recently hit. The replacement also exposes discarded stale responses, since the stale data must never reach `done_data`. Holding the ready input low in the middle of a burst separates a stalled request from a new one.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // per-slot bookkeeping of a stream buffer entry
  typedef struct packed {
    logic req;    // requested for the current stream
    logic busy;   // some request (current or stale) still outstanding
    logic avail;  // data for the current stream has arrived
  } slot_st_t;
endpackage

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] age [N];

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IW'(N - 1)) victim = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(N - 1 - i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + IW'(1);
      end
    end
  end
endmodule

// File: rtl/spf_stream_buf.sv
module spf_stream_buf
  import spf_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int SW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic [AW-1:0] alloc_line,
  input  logic          pop,
  input  logic          issue,
  input  logic [SW-1:0] issue_slot,
  input  logic          rsp_we,
  input  logic [SW-1:0] rsp_slot,
  output logic          active,
  output logic [AW-1:0] head_line,
  output logic [SW-1:0] head_slot,
  output logic          head_avail,
  output logic          rsp_keep,
  output logic          cand_ok,
  output logic [SW-1:0] cand_slot,
  output logic [AW-1:0] cand_line
);
  slot_st_t      st [DEPTH];
  logic [AW-1:0] base;
  logic [SW-1:0] head;

  assign head_line  = base;
  assign head_slot  = head;
  assign head_avail = st[head].avail;
  assign rsp_keep   = st[rsp_slot].req;

  always_comb begin
    cand_ok   = 1'b0;
    cand_slot = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (active && !st[s].req && !st[s].busy) begin
        cand_ok   = 1'b1;
        cand_slot = SW'(s);
      end
    end
    cand_line = base + AW'(SW'(cand_slot - head));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      base   <= '0;
      head   <= '0;
      for (int s = 0; s < DEPTH; s++) st[s] <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (alloc || (pop && head == SW'(s))) begin
          st[s].req   <= 1'b0;
          st[s].avail <= 1'b0;
        end else begin
          if (issue && issue_slot == SW'(s)) st[s].req <= 1'b1;
          if (rsp_we && rsp_slot == SW'(s) && st[s].req) st[s].avail <= 1'b1;
        end
        if (issue && issue_slot == SW'(s)) st[s].busy <= 1'b1;
        else if (rsp_we && rsp_slot == SW'(s)) st[s].busy <= 1'b0;
      end
      if (alloc) begin
        active <= 1'b1;
        base   <= alloc_line + AW'(1);
        head   <= '0;
      end else if (pop) begin
        base <= base + AW'(1);
        head <= head + SW'(1);
      end
    end
  end
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int NBUF  = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int SW   = $clog2(DEPTH),
  localparam int BW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int TW   = BW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_line,
  output logic          done_valid,
  output logic          done_hit,
  output logic [DW-1:0] done_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_line,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_rsp_valid,
  input  logic [TW-1:0] mem_rsp_tag,
  input  logic [DW-1:0] mem_rsp_data
);
  logic [NBUF-1:0] active, head_avail, rsp_keep, cand_ok, hit_vec;
  logic [NBUF-1:0] alloc_v, pop_v, issue_v, rsp_we_v;
  logic [AW-1:0]   head_line [NBUF];
  logic [AW-1:0]   cand_line [NBUF];
  logic [SW-1:0]   head_slot [NBUF];
  logic [SW-1:0]   cand_slot [NBUF];
  logic [DW-1:0]   line_ram  [NBUF*DEPTH];

  logic          any_hit, any_cand, do_pop, do_alloc, load;
  logic [BW-1:0] hit_idx, cand_idx, victim;

  always_comb begin
    any_hit  = 1'b0;
    hit_idx  = '0;
    any_cand = 1'b0;
    cand_idx = '0;
    for (int b = NBUF - 1; b >= 0; b--) begin
      if (hit_vec[b]) begin any_hit = 1'b1; hit_idx = BW'(b); end
      if (cand_ok[b]) begin any_cand = 1'b1; cand_idx = BW'(b); end
    end
  end

  assign do_pop   = miss_valid && !done_valid && any_hit && head_avail[hit_idx];
  assign do_alloc = miss_valid && !done_valid && !any_hit;
  assign load     = !mem_req_valid || mem_req_ready;

  spf_lru #(.N(NBUF), .IW(BW)) u_lru (
    .clk(clk), .rst(rst), .touch(do_pop || do_alloc),
    .touch_idx(do_pop ? hit_idx : victim), .victim(victim)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign hit_vec[b]  = active[b] && (head_line[b] == miss_line);
    assign alloc_v[b]  = do_alloc && (victim == BW'(b));
    assign pop_v[b]    = do_pop && (hit_idx == BW'(b));
    assign issue_v[b]  = load && any_cand && (cand_idx == BW'(b));
    assign rsp_we_v[b] = mem_rsp_valid && (mem_rsp_tag[TW-1:SW] == BW'(b));

    spf_stream_buf #(.AW(AW), .DEPTH(DEPTH), .SW(SW)) u_sb (
      .clk(clk), .rst(rst),
      .alloc(alloc_v[b]), .alloc_line(miss_line), .pop(pop_v[b]),
      .issue(issue_v[b]), .issue_slot(cand_slot[b]),
      .rsp_we(rsp_we_v[b]), .rsp_slot(mem_rsp_tag[SW-1:0]),
      .active(active[b]), .head_line(head_line[b]), .head_slot(head_slot[b]),
      .head_avail(head_avail[b]), .rsp_keep(rsp_keep[b]),
      .cand_ok(cand_ok[b]), .cand_slot(cand_slot[b]), .cand_line(cand_line[b])
    );
  end

  // line storage: one write port (responses), one registered read port (hits)
  always_ff @(posedge clk) begin
    if (mem_rsp_valid && rsp_keep[mem_rsp_tag[TW-1:SW]])
      line_ram[mem_rsp_tag] <= mem_rsp_data;
    done_data <= line_ram[{hit_idx, head_slot[hit_idx]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid    <= 1'b0;
      done_hit      <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      mem_req_tag   <= '0;
    end else begin
      done_valid <= do_pop || do_alloc;
      done_hit   <= do_pop;
      if (load) begin
        mem_req_valid <= any_cand;
        mem_req_line  <= cand_line[cand_idx];
        mem_req_tag   <= {cand_idx, cand_slot[cand_idx]};
      end
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int NBUF  = 4,
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int TW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          miss_valid,
  input logic          done_valid,
  input logic          done_hit,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_line,
  input logic [TW-1:0] mem_req_tag,
  input logic          mem_rsp_valid
);
  localparam int CW = $clog2(NBUF * DEPTH) + 2;
  logic [CW-1:0] outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else outstanding <= outstanding + CW'(mem_req_valid && mem_req_ready) - CW'(mem_rsp_valid);
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_valid && !mem_req_valid));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);
  a_r2_done_needs_miss: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(miss_valid));
  a_r5_hit_in_done: assert property (@(posedge clk) disable iff (rst)
    done_hit |-> done_valid);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_tag)));
  a_r10_outstanding_bound: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CW'(NBUF * DEPTH));
endmodule

bind stream_prefetch spf_checker #(.NBUF(NBUF), .DEPTH(DEPTH), .AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .done_valid(done_valid),
  .done_hit(done_hit), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/stream_prefetch_test.sv
`timescale 1ns/1ps
module stream_prefetch_test;
  localparam int NBUF = 4, DEPTH = 4, AW = 16, DW = 32, TW = 4;

  logic clk = 0, rst = 1;
  logic miss_valid = 0;
  logic [AW-1:0] miss_line = '0;
  logic done_valid, done_hit;
  logic [DW-1:0] done_data;
  logic mem_req_valid, mem_req_ready = 1;
  logic [AW-1:0] mem_req_line;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;

  int checks = 0, fails = 0, cyc = 0, req_n = 0;
  logic [AW-1:0] req_line [64];
  logic [TW-1:0] req_tag  [64];
  int            req_cyc  [64];
  logic got_done, got_hit;
  logic [DW-1:0] got_data;

  always #2.5 clk = ~clk;

  stream_prefetch #(.NBUF(NBUF), .DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (.*);

  function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mem_req_valid && mem_req_ready && req_n < 64) begin
      req_line[req_n] = mem_req_line;
      req_tag[req_n]  = mem_req_tag;
      req_cyc[req_n]  = cyc;
      req_n++;
    end
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected <20000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_miss(input logic [AW-1:0] a);
    miss_line  = a;
    miss_valid = 1;
    got_done   = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done_valid) begin got_done = 1; break; end
    end
    got_hit  = done_hit;
    got_data = done_data;
    miss_valid = 0;
  endtask

  task automatic rsp(input logic [TW-1:0] t, input logic [DW-1:0] d);
    mem_rsp_valid = 1; mem_rsp_tag = t; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 0;
  endtask

  // check n captured requests from index k: lines a+1.., tags tb..
  task automatic chk_burst(input int k, input int n, input logic [AW-1:0] a,
                           input int tb, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req_line[k+i] == a + AW'(i + 1), req, req_line[k+i], a + AW'(i + 1));
      chk(req_tag[k+i] == TW'(tb + i), req, req_tag[k+i], tb + i);
    end
  endtask

  initial begin
    int k;
    idle(3);
    rst = 0;
    idle(3);
    // R1: quiet after reset
    chk(!done_valid, "R1 done", done_valid, 0);
    chk(!mem_req_valid && req_n == 0, "R1 req", req_n, 0);

    // R2, R3, R4: cold miss allocates buffer 0
    do_miss(16'h0100);
    chk(got_done && !got_hit, "R2 cold miss", {got_done, got_hit}, 2'b10);
    @(negedge clk);
    chk(!done_valid, "R2 pulse", done_valid, 0);
    idle(6);
    chk(req_n == 4, "R3 count", req_n, 4);
    chk_burst(0, 4, 16'h0100, 0, "R3 burst");
    for (int i = 1; i < 4; i++)
      chk(req_cyc[i] == req_cyc[i-1] + 1, "R4 back-to-back", req_cyc[i] - req_cyc[i-1], 1);

    for (int i = 0; i < 4; i++) rsp(TW'(i), dval(16'h0101 + AW'(i)));

    // R5: walk the stream, each hit refills one line at the tail
    for (int i = 0; i < 4; i++) begin
      k = req_n;
      do_miss(16'h0101 + AW'(i));
      chk(got_done && got_hit, "R5 hit", got_hit, 1);
      chk(got_data == dval(16'h0101 + AW'(i)), "R5 data", got_data, dval(16'h0101 + AW'(i)));
      idle(4);
      chk(req_n == k + 1, "R5 one refill", req_n - k, 1);
      chk(req_line[k] == 16'h0105 + AW'(i) && req_tag[k] == TW'(i), "R5 refill line/tag",
          req_line[k], 16'h0105 + AW'(i));
    end

    // R6: head 0x105 not yet returned -> stall until response
    miss_line = 16'h0105; miss_valid = 1;
    got_done = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done_valid) got_done = 1;
    end
    chk(!got_done, "R6 stall", got_done, 0);
    rsp(TW'(0), dval(16'h0105));
    for (int i = 0; i < 5; i++) begin
      if (done_valid) break;
      @(negedge clk);
    end
    chk(done_valid && done_hit && done_data == dval(16'h0105), "R6 release", done_data, dval(16'h0105));
    miss_valid = 0;
    idle(4);

    // R7 + R8: non-head line 0x107 (head is 0x106) -> no match, buffer 1
    k = req_n;
    do_miss(16'h0107);
    chk(got_done && !got_hit, "R7 non-head", got_hit, 0);
    idle(6);
    chk(req_n == k + 4, "R8 buf1 count", req_n - k, 4);
    chk_burst(k, 4, 16'h0107, 4, "R8 buf1 tags");

    k = req_n;
    do_miss(16'h0200);
    idle(6);
    chk_burst(k, 4, 16'h0200, 8, "R8 buf2 tags");

    // R4: hold under back-pressure while buffer 3 starts
    mem_req_ready = 0;
    k = req_n;
    do_miss(16'h0300);
    idle(2);
    for (int i = 0; i < 4; i++) begin
      chk(mem_req_valid && mem_req_line == 16'h0301 && mem_req_tag == TW'(12),
          "R4 hold", mem_req_line, 16'h0301);
      @(negedge clk);
    end
    mem_req_ready = 1;
    idle(6);
    chk(req_n == k + 4, "R4 resume count", req_n - k, 4);
    chk_burst(k, 4, 16'h0300, 12, "R8 buf3 tags");

    // touch buffer 0 so buffer 1 becomes LRU
    rsp(TW'(1), dval(16'h0106));
    do_miss(16'h0106);
    chk(got_hit && got_data == dval(16'h0106), "R5 touch", got_data, dval(16'h0106));
    idle(4);

    // R8 + R9: replace buffer 1; its slots still busy with stale requests
    k = req_n;
    do_miss(16'h0400);
    chk(got_done && !got_hit, "R8 replace miss", got_hit, 0);
    idle(6);
    chk(req_n == k, "R9 no reissue while stale", req_n - k, 0);
    rsp(TW'(4), 32'hDEAD_BEEF);   // stale answer for old 0x108
    idle(4);
    chk(req_n == k + 1, "R9 reissue after stale", req_n - k, 1);
    chk(req_line[k] == 16'h0401 && req_tag[k] == TW'(4), "R8 victim is buffer 1",
        req_tag[k], 4);
    // stale data must not satisfy a head match
    miss_line = 16'h0401; miss_valid = 1;
    got_done = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done_valid) got_done = 1;
    end
    chk(!got_done, "R9 stale dropped", got_done, 0);
    rsp(TW'(4), dval(16'h0401));
    for (int i = 0; i < 5; i++) begin
      if (done_valid) break;
      @(negedge clk);
    end
    chk(done_valid && done_hit && done_data == dval(16'h0401), "R9 fresh data",
        done_data, dval(16'h0401));
    miss_valid = 0;
    idle(3);

    summary();
    $finish;
  end
endmodule